// File: doc/BRIEF.md
# Hit Record Word Formatter

This block turns a stream of stored hit records into 16-bit readout words. Each record carries a 16-bit time, an edge flag (rising or falling) and a 5-bit channel number. Two flags mark the record that opens an event and the record that closes it. Before the data of a record flagged as opening an event, the block emits one header word. The header holds a station number, the readout settings and a 3-bit event number that wraps.

In single-word mode the block first subtracts a programmable offset from the time. A record whose result would be negative gives no data word. The result is then shifted right by 0 to 3 bits, and the low 9 bits (both-edge mode) or the low 10 bits (rising-only mode) are kept. In double-word mode the full 16-bit time goes out as two words, high byte first, with no offset and no shift.

The configuration inputs are sampled when a record is accepted. Both streams are valid/ready. A record is taken on a cycle where `rec_valid` and `rec_ready` are both high. An output word moves on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the word on `out_word` stays put and the block holds `rec_ready` low once its internal storage is full. No word is dropped or repeated.

Top module: `hitword_formatter`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `rec_ready` is 1. The event number starts at 0.
- R2: In single-word mode the offset is subtracted before the shift. A record whose time is below the offset produces no data word. A time equal to the offset produces a data word with time field 0.
- R3: `cfg_shift` values 0, 1, 2 and 3 shift the offset-corrected time right by that many bits before truncation.
- R4: A both-edge single data word has the time in [8:0], the edge flag in [9] (1 = falling), the channel in [14:10] and 0 in [15]. Time bits above those kept are dropped, not saturated.
- R5: A rising-only single data word has the time in [9:0], the channel in [14:10] and 0 in [15]. In rising-only mode, records flagged falling produce no data word.
- R6: A header word is emitted ahead of the data of each record with `rec_first` set, even if that record yields no data. Its layout is [15]=1, [14]=double-word mode, [13:11]=event number, [10]=both-edge mode, [9:8]=shift, [7:0]=station.
- R7: The event number advances by one after each accepted record with `rec_last` set, and wraps from 7 to 0.
- R8: In double-word mode each kept hit gives two words, high byte first. Each word has the time byte in [7:0], the byte select in [8] (0 = high, 1 = low), the edge flag in [9], the channel in [14:10] and 0 in [15]. Offset and shift do not apply.
- R9: While `out_valid` is high and `out_ready` is low, `out_word` stays stable. After the stall the pending words come out in order: header first, then the data words.
- R10: The first word of an accepted record appears on `out_valid` on the clock edge after the acceptance edge. `rec_ready` is low while earlier words cannot drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Hit record is offered |
| rec_ready | output | 1 | Block can take a record this cycle |
| rec_first | input | 1 | Record opens an event (header precedes it) |
| rec_last | input | 1 | Record closes an event |
| rec_time | input | 16 | Raw hit time in base ticks |
| rec_falling | input | 1 | 1 = falling edge, 0 = rising edge |
| rec_chan | input | 5 | Channel number |
| cfg_station | input | 8 | Station number placed in headers |
| cfg_shift | input | 2 | Right shift (0 to 3) in single-word mode |
| cfg_both_edges | input | 1 | 1 = both edges recorded, 0 = rising only |
| cfg_double | input | 1 | 1 = double-word readout |
| cfg_offset | input | 16 | Offset subtracted in single-word mode |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Receiver takes the word this cycle |
| out_word | output | 16 | Formatted header or data word |

## Verification
A record is taken at a clock edge. Its first word shows up on `out_valid` one edge later, and each further word of the same record follows one edge after that while `out_ready` is high. The bench drives inputs on the falling edge and samples once per falling edge after the acceptance edge. The first sample falls in the cycle where the header or first data word is due. An extra cycle is then sampled to confirm that nothing more comes out, which is how dropped records are checked. Under back-pressure the bench holds `out_ready` low for several cycles and checks the held word and `rec_ready` at each one. It then releases `out_ready` and collects the words on consecutive cycles.

// File: rtl/hwf_pkg.sv
package hwf_pkg;

  localparam int TIME_W     = 16;
  localparam int CHAN_W     = 5;
  localparam int EVT_W      = 3;
  localparam int STN_W      = 8;
  localparam int SHIFT_W    = 2;
  localparam int WORD_W     = 16;
  localparam int BOTH_TW    = 9;   // time bits kept, both-edge mode
  localparam int RISE_TW    = 10;  // time bits kept, rising-only mode
  localparam int BYTE_W     = TIME_W / 2;
  localparam int NSLOT      = 3;   // header, word 0, word 1
  localparam int SEL_W      = $clog2(NSLOT);

  typedef struct packed {
    logic [TIME_W-1:0] tm;
    logic              fall;
    logic [CHAN_W-1:0] ch;
  } hit_t;

  typedef struct packed {
    logic [STN_W-1:0]   station;
    logic [SHIFT_W-1:0] shift;
    logic               both;
    logic               dbl;
    logic [TIME_W-1:0]  offset;
  } cfg_t;

endpackage

// File: rtl/hwf_time_conv.sv
module hwf_time_conv
  import hwf_pkg::*;
(
  input  hit_t              hit,
  input  cfg_t              cfg,
  output logic              keep,
  output logic [WORD_W-1:0] w0,
  output logic [WORD_W-1:0] w1
);

  logic [TIME_W:0]  diff;
  logic [RISE_TW-1:0] shifted;
  logic             edge_ok;
  logic             below;

  // subtract first, then shift
  assign diff    = {1'b0, hit.tm} - {1'b0, cfg.offset};
  assign below   = diff[TIME_W];
  assign shifted = RISE_TW'(diff[TIME_W-1:0] >> cfg.shift);
  assign edge_ok = cfg.both || !hit.fall;

  always_comb begin
    keep = edge_ok && (cfg.dbl || !below);
    if (cfg.dbl) begin
      w0 = {1'b0, hit.ch, hit.fall, 1'b0, hit.tm[TIME_W-1:BYTE_W]};
      w1 = {1'b0, hit.ch, hit.fall, 1'b1, hit.tm[BYTE_W-1:0]};
    end else if (cfg.both) begin
      w0 = {1'b0, hit.ch, hit.fall, shifted[BOTH_TW-1:0]};
      w1 = '0;
    end else begin
      w0 = {1'b0, hit.ch, shifted};
      w1 = '0;
    end
  end

  always_comb begin
    if (keep && !cfg.both)
      p_rise_only_r5: assert (!hit.fall);
    if (keep && !cfg.dbl)
      p_neg_drop_r2: assert (hit.tm >= cfg.offset);
  end

endmodule

// File: rtl/hwf_event_ctr.sv
module hwf_event_ctr
  import hwf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [EVT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (step) count <= EVT_W'(count + 1'b1);
  end

  p_evt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> count == EVT_W'($past(count) + 1'b1));

  p_evt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(count));

endmodule

// File: rtl/hwf_word_seq.sv
module hwf_word_seq
  import hwf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NSLOT-1:0]  new_pend,
  input  logic [WORD_W-1:0] new_word [NSLOT],
  output logic              can_take,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);

  logic [NSLOT-1:0]  pend;
  logic [NSLOT-1:0]  pend_after;
  logic [NSLOT-1:0]  sel_oh;
  logic [SEL_W-1:0]  sel;
  logic [WORD_W-1:0] word_q [NSLOT];
  logic              slot_free;
  logic              emit;

  // lowest pending slot goes first: header, then word 0, then word 1
  always_comb begin
    sel = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (pend[i]) sel = SEL_W'(i);
    end
    sel_oh = NSLOT'(1) << sel;
  end

  assign slot_free  = !out_valid || out_ready;
  assign emit       = slot_free && (|pend);
  assign pend_after = emit ? (pend & ~sel_oh) : pend;
  assign can_take   = (pend_after == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else if (load) pend <= new_pend;
    else pend <= pend_after;
  end

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n)    word_q[g] <= '0;
        else if (load) word_q[g] <= new_word[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_word  <= word_q[sel];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && (pend == '0) && !load |=> !out_valid);

  p_idle_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> can_take);

  p_first_due_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load && (new_pend != '0) && !out_valid |=> ##1 out_valid);

endmodule

// File: rtl/hitword_formatter.sv
module hitword_formatter
  import hwf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  output logic              rec_ready,
  input  logic              rec_first,
  input  logic              rec_last,
  input  logic [TIME_W-1:0] rec_time,
  input  logic              rec_falling,
  input  logic [CHAN_W-1:0] rec_chan,
  input  logic [STN_W-1:0]  cfg_station,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic              cfg_both_edges,
  input  logic              cfg_double,
  input  logic [TIME_W-1:0] cfg_offset,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);

  hit_t              hit;
  cfg_t              cfg;
  logic              keep;
  logic [WORD_W-1:0] dw0, dw1;
  logic [WORD_W-1:0] hdr;
  logic [EVT_W-1:0]  evt;
  logic              accept;
  logic              can_take;
  logic [NSLOT-1:0]  new_pend;
  logic [WORD_W-1:0] new_word [NSLOT];

  assign hit    = '{tm: rec_time, fall: rec_falling, ch: rec_chan};
  assign cfg    = '{station: cfg_station, shift: cfg_shift, both: cfg_both_edges,
                    dbl: cfg_double, offset: cfg_offset};
  assign accept = rec_valid && can_take;
  assign rec_ready = can_take;

  hwf_time_conv u_conv (
    .hit  (hit),
    .cfg  (cfg),
    .keep (keep),
    .w0   (dw0),
    .w1   (dw1)
  );

  hwf_event_ctr u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (accept && rec_last),
    .count (evt)
  );

  assign hdr = {1'b1, cfg.dbl, evt, cfg.both, cfg.shift, cfg.station};

  assign new_pend    = {keep && cfg.dbl, keep, rec_first};
  assign new_word[0] = hdr;
  assign new_word[1] = dw0;
  assign new_word[2] = dw1;

  hwf_word_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .new_pend  (new_pend),
    .new_word  (new_word),
    .can_take  (can_take),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word)
  );

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

// File: tb/hitword_formatter_tb.sv
`timescale 1ns/100ps
module hitword_formatter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_valid = 1'b0;
  logic        rec_ready;
  logic        rec_first = 1'b0;
  logic        rec_last = 1'b0;
  logic [15:0] rec_time = '0;
  logic        rec_falling = 1'b0;
  logic [4:0]  rec_chan = '0;
  logic [7:0]  cfg_station = '0;
  logic [1:0]  cfg_shift = '0;
  logic        cfg_both_edges = 1'b0;
  logic        cfg_double = 1'b0;
  logic [15:0] cfg_offset = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_word;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  hitword_formatter dut_i (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_first(rec_first), .rec_last(rec_last), .rec_time(rec_time),
    .rec_falling(rec_falling), .rec_chan(rec_chan), .cfg_station(cfg_station),
    .cfg_shift(cfg_shift), .cfg_both_edges(cfg_both_edges), .cfg_double(cfg_double),
    .cfg_offset(cfg_offset), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word)
  );

  typedef struct packed {
    logic        dbl;
    logic        both;
    logic [1:0]  shift;
    logic [15:0] off;
    logic [15:0] tm;
    logic        fall;
    logic [4:0]  ch;
    logic [1:0]  nw;
    logic [15:0] w0;
    logic [15:0] w1;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 2'd0, 16'h0000, 16'h0123, 1'b0, 5'd5,  2'd1, 16'h1523, 16'h0000}, // R4 plain
    '{1'b0, 1'b1, 2'd1, 16'h0010, 16'h0415, 1'b1, 5'd31, 2'd1, 16'h7E02, 16'h0000}, // R3 R4 trunc
    '{1'b0, 1'b0, 2'd2, 16'h0100, 16'h0FFF, 1'b0, 5'd0,  2'd1, 16'h03BF, 16'h0000}, // R2 R5
    '{1'b0, 1'b0, 2'd3, 16'h0000, 16'h2007, 1'b0, 5'd10, 2'd1, 16'h2800, 16'h0000}, // R3 R5 trunc
    '{1'b0, 1'b1, 2'd0, 16'h0200, 16'h01FF, 1'b0, 5'd1,  2'd0, 16'h0000, 16'h0000}, // R2 below
    '{1'b0, 1'b1, 2'd0, 16'h0200, 16'h0200, 1'b0, 5'd3,  2'd1, 16'h0C00, 16'h0000}, // R2 equal
    '{1'b0, 1'b0, 2'd0, 16'h0000, 16'h0050, 1'b1, 5'd4,  2'd0, 16'h0000, 16'h0000}, // R5 falling
    '{1'b1, 1'b1, 2'd3, 16'h1000, 16'hA5C3, 1'b1, 5'd7,  2'd2, 16'h1EA5, 16'h1FC3}  // R8
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic dbl, input logic both, input logic [1:0] sh,
                         input logic [15:0] off, input logic [7:0] stn);
    @(negedge clk);
    cfg_double = dbl; cfg_both_edges = both; cfg_shift = sh;
    cfg_offset = off; cfg_station = stn;
  endtask

  // returns at the falling edge after the acceptance edge
  task automatic send_rec(input logic first, input logic last, input logic [15:0] tm,
                          input logic fall, input logic [4:0] ch);
    @(negedge clk);
    rec_valid = 1'b1; rec_first = first; rec_last = last;
    rec_time = tm; rec_falling = fall; rec_chan = ch;
    while (!rec_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rec_valid = 1'b0; rec_first = 1'b0; rec_last = 1'b0;
  endtask

  task automatic expect_word(input logic [15:0] exp, input string req);
    @(negedge clk);
    check(out_valid === 1'b1 && out_word === exp, req, {15'd0, out_valid, out_word},
          {16'd1, exp});
  endtask

  task automatic expect_none(input string req);
    @(negedge clk);
    check(out_valid === 1'b0, req, {31'd0, out_valid}, 32'd0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++;
      n_errors++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(out_valid === 1'b0, "R1", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1", {31'd0, out_valid}, 32'd0);
    check(rec_ready === 1'b1, "R1", {31'd0, rec_ready}, 32'd1);

    // table walk: single records, no header
    for (int v = 0; v < NVEC; v++) begin
      set_cfg(VECS[v].dbl, VECS[v].both, VECS[v].shift, VECS[v].off, 8'h00);
      send_rec(1'b0, 1'b0, VECS[v].tm, VECS[v].fall, VECS[v].ch);
      if (VECS[v].nw >= 2'd1) expect_word(VECS[v].w0, "R2/R3/R4/R5/R8 word0");
      if (VECS[v].nw == 2'd2) expect_word(VECS[v].w1, "R8 word1");
      expect_none("R2/R5 no extra word");
    end

    // R6 header then data, event 0
    set_cfg(1'b0, 1'b1, 2'd2, 16'h0000, 8'hA7);
    send_rec(1'b1, 1'b1, 16'h0040, 1'b0, 5'd2);
    expect_word(16'h86A7, "R6 header evt0");
    expect_word(16'h0810, "R6 data after header");
    expect_none("R6 end");

    // R6 header for a dropped record, R7 event 1
    set_cfg(1'b0, 1'b1, 2'd2, 16'h0100, 8'hA7);
    send_rec(1'b1, 1'b1, 16'h0010, 1'b0, 5'd2);
    expect_word(16'h8EA7, "R7 header evt1");
    expect_none("R6 dropped record header only");

    // R7 count through wrap
    for (int e = 2; e < 8; e++) begin
      send_rec(1'b1, 1'b1, 16'h0010, 1'b0, 5'd2);
      expect_word(16'h86A7 | 16'(e << 11), "R7 header count");
      expect_none("R7 end");
    end
    send_rec(1'b1, 1'b1, 16'h0010, 1'b0, 5'd2);
    expect_word(16'h86A7, "R7 wrap to 0");
    expect_none("R7 end");

    // R9 back-pressure with a double-word record, event 1
    set_cfg(1'b1, 1'b1, 2'd2, 16'h0000, 8'hA7);
    out_ready = 1'b0;
    send_rec(1'b1, 1'b1, 16'hA5C3, 1'b1, 5'd7);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      check(out_valid === 1'b1 && out_word === 16'hCEA7, "R9 held header",
            {15'd0, out_valid, out_word}, {16'd1, 16'hCEA7});
      check(rec_ready === 1'b0, "R10 ready low while stalled", {31'd0, rec_ready}, 32'd0);
    end
    out_ready = 1'b1;
    check(out_valid === 1'b1 && out_word === 16'hCEA7, "R9 header at release",
          {15'd0, out_valid, out_word}, {16'd1, 16'hCEA7});
    expect_word(16'h1EA5, "R9 R8 high byte");
    expect_word(16'h1FC3, "R9 R8 low byte");
    expect_none("R9 drained");
    check(rec_ready === 1'b1, "R10 ready after drain", {31'd0, rec_ready}, 32'd1);

    finish_run();
  end

endmodule